// File: doc/BRIEF.md
# Two-Lane Unfolded First-Order Recursive Filter

This block computes the recursion y(n) = a·y(n−9) + x(n) at two samples per clock. On every enabled clock edge it takes the sample pair x(2k) (even lane) and x(2k+1) (odd lane) and produces y(2k) and y(2k+1) on that same edge. Because two samples pass per clock, the clock period is twice the sample period. Serial-to-parallel and parallel-to-serial conversion sit outside the block.

A delay of nine samples is an odd count, so it does not split evenly across two lanes. The even result needs the odd-lane output from five enabled cycles back. The odd result needs the even-lane output from four enabled cycles back. The history therefore uses a four-deep chain on the even lane and a five-deep chain on the odd lane. These nine registers match the nine sample delays of the serial recursion, and the first stage of each chain is also the lane's output register.

Samples are 16-bit signed two's complement. The coefficient is signed Q1.15. Each product is truncated toward minus infinity back to Q1.15, added to the input sample, and saturated to 16 bits.

Top module: `unfold2_recursive_filter`

## Requirements
- R1: On a rising edge with `in_en` high, new results are loaded into `y_even` and `y_odd`. `y_valid` is high in the cycle after an edge where `in_en` was high, and low in the cycle after an edge where it was low.
- R2: For enabled cycle k, counted since reset, `y_even` = sat(trunc(a·O[k−5]) + x_even). O[j] is the `y_odd` result of enabled cycle j, and O[j] = 0 for j < 0.
- R3: For enabled cycle k, `y_odd` = sat(trunc(a·E[k−4]) + x_odd). E[j] is the `y_even` result of enabled cycle j, and E[j] = 0 for j < 0.
- R4: trunc(p) is the 32-bit signed product of the history word and `coef_a`, shifted arithmetically right by 15 bits, which rounds toward minus infinity. For example, a = −1 (16'hFFFF) times 1 gives −1.
- R5: A sum above 32767 yields 32767, and a sum below −32768 yields −32768. Nonnegative operands never produce a negative result.
- R6: Driving `rst_n` low clears the outputs, `y_valid` and all history to zero at once. After reset, each lane's output equals its input alone until that lane's history source has filled.
- R7: A clock edge with `in_en` low changes neither the outputs nor the history. The enabled cycle that follows uses the same history as if the idle cycle had not occurred.
- R8: `coef_a` is taken fresh on every enabled edge. With `coef_a` = 0, each output equals the input sample of the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one edge per sample pair |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_en | input | 1 | Advances the recursion on this edge |
| coef_a | input | 16 | Feedback coefficient, signed Q1.15 |
| x_even | input | 16 | Sample x(2k), signed |
| x_odd | input | 16 | Sample x(2k+1), signed |
| y_even | output | 16 | Result y(2k), registered |
| y_odd | output | 16 | Result y(2k+1), registered |
| y_valid | output | 1 | High after an enabled edge |

## Verification
A short run right after reset, with half-scale gain, shows whether each lane passes its input through untouched while its history is still empty. A zero coefficient removes the feedback, so any error in the input path shows up alone. Long random runs with random coefficients, full-range samples and idle gaps compare both lanes against the recursion. These runs separate a correct 5/4 tap split from a swapped or uniform one, and show that idle edges do not advance the history. Directed runs cover the rest: constant full-scale inputs drive both saturation limits, a coefficient of −1 applied to a history of 1 separates floor truncation from rounding toward zero, and a reset in mid-run checks that the history is cleared.

// File: rtl/ufr_pkg.sv
package ufr_pkg;

  localparam int LANES = 2;

  // Lane whose history feeds output lane `lane` for a recursion delay `dly`.
  function automatic int src_lane(input int lane, input int dly);
    return ((lane - dly) % LANES + LANES) % LANES;
  endfunction

  // How many enabled cycles back that history word was produced.
  function automatic int tap_depth(input int lane, input int dly);
    return (dly - lane + src_lane(lane, dly)) / LANES;
  endfunction

  // Chain length stored by lane `s`: the tap depth of the one lane reading it.
  function automatic int store_depth(input int s, input int dly);
    return tap_depth((s + dly) % LANES, dly);
  endfunction

endpackage

// File: rtl/ufr_lane_mac.sv
module ufr_lane_mac #(
  parameter int DW   = 16,
  parameter int CW   = 16,
  parameter int FRAC = 15
) (
  input  logic signed [DW-1:0] x_in,
  input  logic signed [DW-1:0] hist,
  input  logic signed [CW-1:0] coef,
  output logic signed [DW-1:0] y_out
);

  localparam int PW = DW + CW;
  localparam int SW = PW + 1;
  localparam logic signed [SW-1:0] YMAX = {{(SW-DW+1){1'b0}}, {(DW-1){1'b1}}};
  localparam logic signed [SW-1:0] YMIN = {{(SW-DW+1){1'b1}}, {(DW-1){1'b0}}};

  logic signed [PW-1:0] prod;
  logic signed [PW-1:0] scaled;
  logic signed [SW-1:0] sum;

  always_comb begin
    prod   = hist * coef;
    scaled = prod >>> FRAC;
    sum    = {scaled[PW-1], scaled} + {{(SW-DW){x_in[DW-1]}}, x_in};
    if (sum > YMAX) begin
      y_out = YMAX[DW-1:0];
    end else if (sum < YMIN) begin
      y_out = YMIN[DW-1:0];
    end else begin
      y_out = sum[DW-1:0];
    end
  end

  // R5: clamping never flips the sign of the result
  always_comb begin
    if (x_in >= 0 && scaled >= 0) begin
      assert_no_wrap_pos_R5: assert (y_out >= 0)
        else $error("positive operands gave negative result");
    end
    if (x_in < 0 && scaled < 0) begin
      assert_no_wrap_neg_R5: assert (y_out < 0)
        else $error("negative operands gave nonnegative result");
    end
  end

endmodule

// File: rtl/ufr_delay_line.sv
module ufr_delay_line #(
  parameter int DW    = 16,
  parameter int DEPTH = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic signed [DW-1:0] din,
  output logic signed [DW-1:0] head,
  output logic signed [DW-1:0] tap
);

  localparam int CNTW = $clog2(DEPTH + 1);
  localparam logic [CNTW-1:0] DEPTH_C = CNTW'(DEPTH);

  logic signed [DW-1:0] stage_q [DEPTH];
  logic signed [DW-1:0] stage_d [DEPTH];

  always_comb begin
    stage_d[0] = din;
    for (int j = 1; j < DEPTH; j++) begin
      stage_d[j] = stage_q[j-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int j = 0; j < DEPTH; j++) begin
        stage_q[j] <= '0;
      end
    end else if (en) begin
      for (int j = 0; j < DEPTH; j++) begin
        stage_q[j] <= stage_d[j];
      end
    end
  end

  assign head = stage_q[0];
  assign tap  = stage_q[DEPTH-1];

  // Checker state: enabled cycles since reset, saturating at DEPTH.
  logic [CNTW-1:0] fill_q;
  logic [CNTW-1:0] fill_d;

  always_comb begin
    fill_d = fill_q;
    if (en && fill_q < DEPTH_C) begin
      fill_d = fill_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_q <= '0;
    end else begin
      fill_q <= fill_d;
    end
  end

  // R6: until the chain has filled, the oldest word is still the reset zero
  assert_unfilled_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_q < DEPTH_C) |-> (tap == '0));

endmodule

// File: rtl/unfold2_recursive_filter.sv
module unfold2_recursive_filter #(
  parameter int DW    = 16,
  parameter int CW    = 16,
  parameter int FRAC  = 15,
  parameter int DELAY = 9
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_en,
  input  logic signed [CW-1:0] coef_a,
  input  logic signed [DW-1:0] x_even,
  input  logic signed [DW-1:0] x_odd,
  output logic signed [DW-1:0] y_even,
  output logic signed [DW-1:0] y_odd,
  output logic                 y_valid
);

  localparam int NL = ufr_pkg::LANES;

  logic signed [DW-1:0] x_lane [NL];
  logic signed [DW-1:0] y_new  [NL];
  logic signed [DW-1:0] head   [NL];
  logic signed [DW-1:0] tap    [NL];

  always_comb begin
    x_lane[0] = x_even;
    x_lane[1] = x_odd;
  end

  for (genvar l = 0; l < NL; l++) begin : g_lane
    localparam int SRC  = ufr_pkg::src_lane(l, DELAY);
    localparam int KEEP = ufr_pkg::store_depth(l, DELAY);

    ufr_lane_mac #(.DW(DW), .CW(CW), .FRAC(FRAC)) u_mac (
      .x_in  (x_lane[l]),
      .hist  (tap[SRC]),
      .coef  (coef_a),
      .y_out (y_new[l])
    );

    ufr_delay_line #(.DW(DW), .DEPTH(KEEP)) u_hist (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (in_en),
      .din   (y_new[l]),
      .head  (head[l]),
      .tap   (tap[l])
    );
  end

  assign y_even = head[0];
  assign y_odd  = head[1];

  logic valid_d;
  logic valid_q;

  always_comb begin
    valid_d = in_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= valid_d;
    end
  end

  assign y_valid = valid_q;

  // R1: y_valid follows the enable of the previous edge
  assert_valid_after_en_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_en |=> y_valid);
  assert_valid_low_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_en |=> !y_valid);

  // R7: an idle edge leaves both outputs untouched
  assert_hold_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_en |=> ($stable(y_even) && $stable(y_odd)));

  // R8: a zero coefficient passes the inputs straight through
  assert_zero_coef_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_en && coef_a == '0) |=>
      (y_even == $past(x_even) && y_odd == $past(x_odd)));

endmodule

// File: tb/tb_unfold2_recursive_filter.sv
`timescale 1ns/1ps
module tb_unfold2_recursive_filter;

  logic clk;
  logic rst_n;
  logic in_en;
  logic signed [15:0] coef_a;
  logic signed [15:0] x_even;
  logic signed [15:0] x_odd;
  logic signed [15:0] y_even;
  logic signed [15:0] y_odd;
  logic y_valid;

  unfold2_recursive_filter dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_en   (in_en),
    .coef_a  (coef_a),
    .x_even  (x_even),
    .x_odd   (x_odd),
    .y_even  (y_even),
    .y_odd   (y_odd),
    .y_valid (y_valid)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  int ev_hist [0:2047];
  int od_hist [0:2047];
  int k = 0;
  int prev_e = 0;
  int prev_o = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Recursion arithmetic from R4 and R5.
  function automatic int lane_model(input int x, input int a, input int h);
    longint p;
    longint s;
    p = longint'(a) * longint'(h);
    p = p >>> 15;
    s = p + longint'(x);
    if (s > 32767) s = 32767;
    if (s < -32768) s = -32768;
    return int'(s);
  endfunction

  function automatic int rnd16();
    logic signed [15:0] t;
    t = 16'($urandom);
    return int'(t);
  endfunction

  task automatic do_reset();
    #1;
    rst_n = 1'b0;
    in_en = 1'b0;
    #1;
    chk(y_even == 0, "R6 reset y_even", int'(y_even), 0);
    chk(y_odd == 0, "R6 reset y_odd", int'(y_odd), 0);
    chk(y_valid == 1'b0, "R6 reset y_valid", int'(y_valid), 0);
    repeat (2) @(posedge clk);
    #1;
    rst_n = 1'b1;
    k = 0;
    prev_e = 0;
    prev_o = 0;
  endtask

  // Drive one sample pair, wait one edge, check against the model (R1 R2 R3 R7).
  task automatic step(input bit en_i, input int xe, input int xo, input int a);
    int ee;
    int eo;
    in_en  = en_i;
    x_even = 16'(xe);
    x_odd  = 16'(xo);
    coef_a = 16'(a);
    @(posedge clk);
    #1;
    if (en_i) begin
      ee = lane_model(xe, a, (k >= 5) ? od_hist[k-5] : 0);
      eo = lane_model(xo, a, (k >= 4) ? ev_hist[k-4] : 0);
      if (k < 2048) begin
        ev_hist[k] = ee;
        od_hist[k] = eo;
      end
      k++;
      chk(y_even == ee, "R2 even lane", int'(y_even), ee);
      chk(y_odd == eo, "R3 odd lane", int'(y_odd), eo);
      chk(y_valid == 1'b1, "R1 valid after enable", int'(y_valid), 1);
      prev_e = ee;
      prev_o = eo;
    end else begin
      chk(y_even == prev_e, "R7 hold y_even", int'(y_even), prev_e);
      chk(y_odd == prev_o, "R7 hold y_odd", int'(y_odd), prev_o);
      chk(y_valid == 1'b0, "R1 valid low when idle", int'(y_valid), 0);
    end
  endtask

  initial begin
    int xe;
    int xo;
    void'($urandom(32'd20240607));
    rst_n  = 1'b0;
    in_en  = 1'b0;
    coef_a = '0;
    x_even = '0;
    x_odd  = '0;
    @(posedge clk);
    do_reset();

    // R6: history empty, outputs equal inputs
    for (int i = 0; i < 8; i++) begin
      xe = rnd16();
      xo = rnd16();
      step(1'b1, xe, xo, 16384);
      if (i < 4) begin
        chk(y_even == 16'(xe), "R6 unfilled even", int'(y_even), xe);
        chk(y_odd == 16'(xo), "R6 unfilled odd", int'(y_odd), xo);
      end
    end

    // R8: zero coefficient
    for (int i = 0; i < 5; i++) begin
      xe = rnd16();
      xo = rnd16();
      step(1'b1, xe, xo, 0);
      chk(y_even == 16'(xe), "R8 zero coef even", int'(y_even), xe);
      chk(y_odd == 16'(xo), "R8 zero coef odd", int'(y_odd), xo);
    end

    // R7: directed idle gap, then resume
    for (int i = 0; i < 3; i++) step(1'b0, rnd16(), rnd16(), rnd16());
    for (int i = 0; i < 6; i++) step(1'b1, rnd16(), rnd16(), 20000);

    // R2 R3: random stimulus with idle gaps
    for (int i = 0; i < 400; i++) begin
      step(($urandom % 4) != 0, rnd16(), rnd16(), rnd16());
    end

    // R5: positive saturation
    do_reset();
    for (int i = 0; i < 12; i++) begin
      step(1'b1, 32767, 32767, 32767);
      chk(y_even == 16'sd32767, "R5 positive limit even", int'(y_even), 32767);
    end
    // R5: negative saturation
    do_reset();
    for (int i = 0; i < 12; i++) begin
      step(1'b1, -32768, -32768, 32767);
      chk(y_odd == -16'sd32768, "R5 negative limit odd", int'(y_odd), -32768);
    end
    // R5: most negative coefficient times most negative history
    for (int i = 0; i < 6; i++) step(1'b1, 0, 100, -32768);

    // R4: floor truncation, -1 * 1 gives -1
    do_reset();
    step(1'b1, 1, 1, 0);
    for (int i = 0; i < 3; i++) step(1'b1, 0, 0, 0);
    step(1'b1, 0, 0, -1);
    chk(y_odd == -16'sd1, "R4 floor odd", int'(y_odd), -1);
    step(1'b1, 0, 0, -1);
    chk(y_even == -16'sd1, "R4 floor even", int'(y_even), -1);
    step(1'b1, 0, 0, 1);

    // R6: reset in mid-run, then refill
    for (int i = 0; i < 10; i++) step(1'b1, rnd16(), rnd16(), rnd16());
    do_reset();
    for (int i = 0; i < 8; i++) step(1'b1, rnd16(), rnd16(), rnd16());

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL R1 watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

endmodule